// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block produces external bus cycles on an 8-bit bus where the low address byte and the data share the same eight lines. A requester inside the chip hands over one transfer at a time: read or write, an 8-bit offset inside a 256-byte I/O window, write data, and the index of the peripheral window to select. The controller then runs a fixed four-state cycle on the pins and reports completion with a one-clock done pulse. On a read, the captured byte comes back with that pulse.

The pin side has separate output, output-enable and input vectors for the shared lines, so the pad ring can build the tri-state driver. The controller also drives an address-latch strobe for an external transparent latch, active-low read and write strobes, the three lowest address bits on their own pins, and seven active-low window selects. Indices 0, 1, 2, 3, 5 and 6 are real selects. Indices 4 and 7 select nothing. A hold input parks the shared lines at high impedance and keeps the controller idle.

States and transitions, all named:
- IDLE -> T1 when a request is present and hold is low.
- T1 -> T2 -> T3 -> T4 unconditionally.
- T4 -> IDLE, with done raised in the first IDLE clock.

Top module: `mbc_top`

## Requirements
- R1: While rst_n is low, and in the first idle cycle after it, ad_oe=0, ale=0, rd_n=1, wr_n=1, pcs_n=7'h7F, rsp_done=0. req_ready is 1 when bus_hold is 0. Asserting rst_n low in mid-cycle returns the pins to this state at once.
- R2: A request (req_valid=1) is taken only when req_ready=1, that is, in IDLE with bus_hold=0. Requests presented during T1..T4 are ignored and start no extra cycle.
- R3: In T1 (the clock after acceptance), ale=1, ad_oe=1, ad_out equals the 8-bit offset, and a_lo equals offset bits [2:0]. ale is 0 in T2, T3 and T4.
- R4: In a read (req_write=0), rd_n is 0 in T2 and T3 and 1 otherwise, ad_oe is 0 in T2..T4, and wr_n stays 1.
- R5: In a write (req_write=1), wr_n is 0 in T2 and T3 and 1 otherwise, ad_oe=1 with ad_out equal to the write data in T2..T4, and rd_n stays 1.
- R6: For req_cs in {0,1,2,3,5,6}, pcs_n bit [req_cs] is 0 from T1 through T4 and every other bit is 1. For req_cs 4 or 7, all bits stay 1. At most one bit is ever low.
- R7: Read data is the value on ad_in at the end of T3. A change on ad_in during T4 does not reach rsp_rdata.
- R8: rsp_done is 1 for exactly one clock, the clock after T4. req_ready is 1 in that same clock, so a request presented then starts T1 on the next clock.
- R9: While bus_hold=1 in IDLE, req_ready=0, no cycle starts and ad_oe=0. Raising bus_hold during T1..T4 does not stop the cycle in progress.
- R10: In IDLE, ale=0, ad_oe=0, rd_n=1, wr_n=1, a_lo=0 and pcs_n=7'h7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Window select index |
| req_addr | input | 8 | Offset within the 256-byte window |
| req_wdata | input | 8 | Write data |
| bus_hold | input | 1 | Park the bus (lines high impedance, no new cycle) |
| ad_in | input | 8 | Shared lines as seen from the pads |
| req_ready | output | 1 | Controller can accept a request |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Captured read byte |
| ad_out | output | 8 | Value driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| a_lo | output | 3 | Dedicated low address pins |
| pcs_n | output | 7 | Active-low window selects, bit = index |

## Verification
A state register stuck or skipped shows up at the pins within one clock. The strobe pattern follows the state directly: ale high only in T1, strobes low only in T2 and T3, and a window select held through T4. So any out-of-order state breaks a per-state pin check in the cycle it occurs. A wrong capture instant shows only when done arrives, four clocks after acceptance. The bench therefore changes ad_in in T4 so that a late capture returns the wrong byte. A wrongly latched request is seen as a bad ad_out or pcs_n in T1, or as a second spurious cycle after the first done.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_T4   = 3'd4
    } bus_state_t;

endpackage

// File: rtl/mbc_cs_decode.sv
module mbc_cs_decode #(
    parameter int          NUM_CS  = 7,
    parameter int          IDX_W   = 3,
    parameter logic [NUM_CS-1:0] CS_MASK = 7'b1101111
) (
    input  logic              active,
    input  logic [IDX_W-1:0]  idx,
    output logic [NUM_CS-1:0] pcs_n
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
        if (CS_MASK[g]) begin : g_real
            assign pcs_n[g] = !(active && (idx == IDX_W'(g)));
        end else begin : g_absent
            assign pcs_n[g] = 1'b1;
        end
    end

endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
#(
    parameter int AD_W  = 8,
    parameter int ALO_W = 3,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_cs,
    input  logic [AD_W-1:0]  req_addr,
    input  logic [AD_W-1:0]  req_wdata,
    input  logic             bus_hold,
    output logic             req_ready,
    output logic [AD_W-1:0]  ad_out,
    output logic             ad_oe,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic [ALO_W-1:0] a_lo,
    output logic             cs_active,
    output logic [IDX_W-1:0] cs_idx,
    output logic             cap_en,
    output logic             last_state
);

    bus_state_t       st, st_nx;
    logic             lat_wr;
    logic [AD_W-1:0]  lat_addr;
    logic [AD_W-1:0]  lat_wdata;
    logic [IDX_W-1:0] lat_cs;
    logic             accept;

    assign accept = (st == ST_IDLE) && !bus_hold && req_valid;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (accept) st_nx = ST_T1;
            ST_T1:   st_nx = ST_T2;
            ST_T2:   st_nx = ST_T3;
            ST_T3:   st_nx = ST_T4;
            ST_T4:   st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_wr    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_cs    <= '0;
        end else if (accept) begin
            lat_wr    <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_cs    <= req_cs;
        end
    end

    always_comb begin
        req_ready  = 1'b0;
        ad_out     = '0;
        ad_oe      = 1'b0;
        ale        = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        a_lo       = '0;
        cs_active  = 1'b0;
        cap_en     = 1'b0;
        last_state = 1'b0;
        unique case (st)
            ST_IDLE: begin
                req_ready = !bus_hold;
            end
            ST_T1: begin
                ale       = 1'b1;
                ad_oe     = 1'b1;
                ad_out    = lat_addr;
                a_lo      = lat_addr[ALO_W-1:0];
                cs_active = 1'b1;
            end
            ST_T2, ST_T3: begin
                rd_n      = lat_wr;
                wr_n      = !lat_wr;
                ad_oe     = lat_wr;
                ad_out    = lat_wr ? lat_wdata : '0;
                a_lo      = lat_addr[ALO_W-1:0];
                cs_active = 1'b1;
                cap_en    = (st == ST_T3) && !lat_wr;
            end
            ST_T4: begin
                ad_oe      = lat_wr;
                ad_out     = lat_wr ? lat_wdata : '0;
                a_lo       = lat_addr[ALO_W-1:0];
                cs_active  = 1'b1;
                last_state = 1'b1;
            end
            default: ;
        endcase
    end

    assign cs_idx = lat_cs;

    // R3
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_T1) |=> (st == ST_T2 && !ale));

    // R9
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && bus_hold) |=> (st == ST_IDLE));

    // R2
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> ($stable(lat_addr) && $stable(lat_wr) && $stable(lat_cs)));

    // R4
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n) |-> (!ad_oe && wr_n));

    // R5
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n) |-> (ad_oe && rd_n && !ale));

endmodule

// File: rtl/mbc_rdcap.sv
module mbc_rdcap #(
    parameter int AD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic            last_state,
    input  logic [AD_W-1:0] ad_in,
    output logic [AD_W-1:0] rdata,
    output logic            done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            if (cap_en) rdata <= ad_in;
            done <= last_state;
        end
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    hold_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && $past(!cap_en)) |-> $stable(rdata));

endmodule

// File: rtl/mbc_top.sv
module mbc_top #(
    parameter int                AD_W    = 8,
    parameter int                ALO_W   = 3,
    parameter int                IDX_W   = 3,
    parameter int                NUM_CS  = 7,
    parameter logic [NUM_CS-1:0] CS_MASK = 7'b1101111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_cs,
    input  logic [AD_W-1:0]   req_addr,
    input  logic [AD_W-1:0]   req_wdata,
    input  logic              bus_hold,
    input  logic [AD_W-1:0]   ad_in,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [AD_W-1:0]   rsp_rdata,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ALO_W-1:0]  a_lo,
    output logic [NUM_CS-1:0] pcs_n
);

    logic             cs_active;
    logic [IDX_W-1:0] cs_idx;
    logic             cap_en;
    logic             last_state;

    mbc_seq #(
        .AD_W (AD_W),
        .ALO_W(ALO_W),
        .IDX_W(IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_hold  (bus_hold),
        .req_ready (req_ready),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .a_lo      (a_lo),
        .cs_active (cs_active),
        .cs_idx    (cs_idx),
        .cap_en    (cap_en),
        .last_state(last_state)
    );

    mbc_cs_decode #(
        .NUM_CS (NUM_CS),
        .IDX_W  (IDX_W),
        .CS_MASK(CS_MASK)
    ) u_cs (
        .active(cs_active),
        .idx   (cs_idx),
        .pcs_n (pcs_n)
    );

    mbc_rdcap #(
        .AD_W(AD_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .last_state(last_state),
        .ad_in     (ad_in),
        .rdata     (rsp_rdata),
        .done      (rsp_done)
    );

    // R6
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pcs_n));

    // R8
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!ale && rd_n && wr_n && (&pcs_n)));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && (!rd_n || !wr_n)));

endmodule

// File: tb/mbc_top_test.sv
module mbc_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [2:0] req_cs = '0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       bus_hold = 1'b0;
    logic [7:0] ad_in = '0;
    logic       req_ready, rsp_done, ad_oe, ale, rd_n, wr_n;
    logic [7:0] rsp_rdata, ad_out;
    logic [2:0] a_lo;
    logic [6:0] pcs_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mbc_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .bus_hold(bus_hold), .ad_in(ad_in), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ad_out(ad_out),
        .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .a_lo(a_lo),
        .pcs_n(pcs_n)
    );

    // fields: write[27], cs[26:24], addr[23:16], wdata[15:8], read-back value[7:0]
    localparam logic [27:0] VEC [8] = '{
        {1'b0, 3'd0, 8'h3C, 8'h00, 8'hA5},
        {1'b1, 3'd1, 8'hF1, 8'h5A, 8'h00},
        {1'b0, 3'd5, 8'h07, 8'h00, 8'h00},
        {1'b1, 3'd6, 8'h80, 8'hFF, 8'h00},
        {1'b0, 3'd4, 8'h12, 8'h00, 8'hC3},
        {1'b1, 3'd3, 8'h00, 8'h01, 8'h00},
        {1'b0, 3'd2, 8'hFF, 8'h00, 8'h7E},
        {1'b1, 3'd7, 8'h55, 8'h99, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_pcs(input logic [2:0] idx);
        if (idx == 3'd4 || idx == 3'd7) return 7'h7F;
        return ~(7'b1 << idx);
    endfunction

    task automatic idle_pins(input string tag);
        chk({tag, " R10 ale"}, ale, 1'b0);
        chk({tag, " R10 oe"}, ad_oe, 1'b0);
        chk({tag, " R10 strobes"}, {rd_n, wr_n}, 2'b11);
        chk({tag, " R10 a_lo"}, a_lo, 3'd0);
        chk({tag, " R10 pcs"}, pcs_n, 7'h7F);
    endtask

    task automatic run_cycle(input logic wr, input logic [2:0] idx, input logic [7:0] a,
                             input logic [7:0] wd, input logic [7:0] rv);
        @(negedge clk);
        chk("R2 ready before request", req_ready, 1'b1);
        req_valid = 1'b1; req_write = wr; req_cs = idx; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 ale in T1", ale, 1'b1);
        chk("R3 oe in T1", ad_oe, 1'b1);
        chk("R3 address on lines", ad_out, a);
        chk("R3 a_lo", a_lo, a[2:0]);
        chk("R6 pcs in T1", pcs_n, exp_pcs(idx));
        chk("R4 R5 strobes idle in T1", {rd_n, wr_n}, 2'b11);
        for (int s = 2; s <= 3; s++) begin
            @(negedge clk);
            chk("R3 ale low", ale, 1'b0);
            chk("R6 pcs held", pcs_n, exp_pcs(idx));
            if (wr) begin
                chk("R5 wr_n low", {rd_n, wr_n}, 2'b10);
                chk("R5 oe", ad_oe, 1'b1);
                chk("R5 data", ad_out, wd);
            end else begin
                chk("R4 rd_n low", {rd_n, wr_n}, 2'b01);
                chk("R4 released", ad_oe, 1'b0);
            end
            ad_in = rv;
        end
        @(negedge clk);
        ad_in = ~rv;
        chk("R4 R5 strobes off in T4", {rd_n, wr_n}, 2'b11);
        chk("R6 pcs in T4", pcs_n, exp_pcs(idx));
        chk("R3 ale low in T4", ale, 1'b0);
        chk("R8 no early done", rsp_done, 1'b0);
        if (wr) begin
            chk("R5 oe in T4", ad_oe, 1'b1);
            chk("R5 data in T4", ad_out, wd);
        end else begin
            chk("R4 released in T4", ad_oe, 1'b0);
        end
        @(negedge clk);
        chk("R8 done pulse", rsp_done, 1'b1);
        chk("R8 ready with done", req_ready, 1'b1);
        if (!wr) chk("R7 read data from end of T3", rsp_rdata, rv);
        idle_pins("after cycle");
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        chk("R1 oe in reset", ad_oe, 1'b0);
        chk("R1 pcs in reset", pcs_n, 7'h7F);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", rsp_done, 1'b0);
        chk("R1 ready after reset", req_ready, 1'b1);
        idle_pins("R1 reset");

        for (int i = 0; i < 8; i++) begin
            run_cycle(VEC[i][27], VEC[i][26:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
            @(negedge clk);
            chk("R8 done single clock", rsp_done, 1'b0);
        end

        // R2: requests while busy are ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_cs = 3'd1; req_addr = 8'h44;
        @(negedge clk);
        req_write = 1'b1; req_cs = 3'd6; req_addr = 8'hEE; req_wdata = 8'h11;
        @(negedge clk);
        chk("R2 busy request ignored T2", {rd_n, wr_n}, 2'b01);
        chk("R2 busy request pcs", pcs_n, exp_pcs(3'd1));
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 first cycle done", rsp_done, 1'b1);
        @(negedge clk);
        chk("R2 no second cycle", ale, 1'b0);
        chk("R2 no second done", rsp_done, 1'b0);

        // R8: back-to-back request in the done clock
        run_cycle(1'b1, 3'd2, 8'h21, 8'h3E, 8'h00);
        req_valid = 1'b1; req_write = 1'b0; req_cs = 3'd0; req_addr = 8'h6B;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 back-to-back T1", ale, 1'b1);
        chk("R8 back-to-back address", ad_out, 8'h6B);
        repeat (4) @(negedge clk);
        chk("R8 back-to-back done", rsp_done, 1'b1);

        // R9: hold blocks new cycles and parks the lines
        @(negedge clk);
        bus_hold = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_cs = 3'd3; req_addr = 8'h9A; req_wdata = 8'h77;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 ready low in hold", req_ready, 1'b0);
            chk("R9 no cycle in hold", ale, 1'b0);
            chk("R9 lines parked", ad_oe, 1'b0);
        end
        bus_hold = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 starts after hold", ale, 1'b1);
        chk("R9 address after hold", ad_out, 8'h9A);
        bus_hold = 1'b1;
        @(negedge clk);
        chk("R9 cycle continues in hold", wr_n, 1'b0);
        repeat (3) @(negedge clk);
        chk("R9 done under hold", rsp_done, 1'b1);
        chk("R9 ready low after done in hold", req_ready, 1'b0);
        bus_hold = 1'b0;

        // R1: reset in mid-cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_cs = 3'd5; req_addr = 8'h10;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 mid-cycle reset strobes", {rd_n, wr_n}, 2'b11);
        chk("R1 mid-cycle reset oe", ad_oe, 1'b0);
        chk("R1 mid-cycle reset pcs", pcs_n, 7'h7F);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after mid-cycle reset", req_ready, 1'b1);
        chk("R1 no done after reset", rsp_done, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule